// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block counts bus clock cycles while it is enabled and compares the count against a period chosen from sixteen powers of two. On the first expiry of the period it raises a fast-interrupt request and sets a status flag. Software answers by writing a clear command. If the flag is still set when the period expires again, the block emits a one-cycle reset-request pulse for the chip reset logic. A second mode skips the interrupt stage and requests a reset at every expiry.

Configuration arrives through a plain write port with two addresses: a configuration word and a command word. Once software sets the lock bit, later writes cannot change the enable, mode or period. Only a reset removes the lock. The shortest period is `2^MIN_EXP` cycles. Silicon uses the default of 16, which gives periods from 2^16 to 2^31 cycles. A bench may lower the parameter to keep runs short.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, `irq_o`, `flag_o`, `rst_req_o` and `locked_o` are low and the timer is disabled.
- R2: Writing 1 to bit 0 of the configuration word (address 0) enables counting. While this bit is 0, no expiry occurs and the count stays at zero. The first expiry completes on the clock edge that lies one period after the edge that took the enabling write.
- R3: Bits [5:2] of the configuration word select the period, which is 2^(MIN_EXP+select) clock cycles.
- R4: With bit 1 of the configuration word at 0 (two-stage mode), an expiry with the flag clear sets `flag_o` and `irq_o` high on the edge that ends the period.
- R5: In two-stage mode, an expiry while the flag is set drives `rst_req_o` high for exactly one cycle, starting at the edge that ends that period. The flag stays set.
- R6: Writing 1 to bit 1 of the command word (address 1) clears `flag_o` and `irq_o` on that edge. The next expiry then behaves as a first stage and requests no reset.
- R7: Writing 1 to bit 0 of the command word restarts the count from zero, so the next expiry comes one full period after that write. The flag is left unchanged.
- R8: With bit 1 of the configuration word at 1 (direct mode), every expiry produces a one-cycle `rst_req_o` pulse and the flag is never set.
- R9: Writing 1 to bit 6 of the configuration word sets the lock, which `locked_o` shows. While the lock is set, writes to the enable, mode and period fields are ignored. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the count advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 1 | 0 selects the configuration word, 1 the command word |
| wr_data | input | DATA_W | Write data |
| irq_o | output | 1 | Fast-interrupt request, high while the flag is set |
| flag_o | output | 1 | First-stage status flag |
| rst_req_o | output | 1 | One-cycle reset request |
| locked_o | output | 1 | Configuration lock is active |

## Verification
The properties assume that `wr_en` is a clean one-cycle strobe sampled at the rising edge, with `wr_addr` and `wr_data` stable around that edge. They also assume that the reset request does not feed back into `rst_n` within the same run. The stimulus drives every write on the falling edge, holds it for exactly one rising edge, and uses `rst_n` only from the bench's own reset task. No write lands on the edge where the period expires, so the same-edge races between clear, restart and expiry stay outside the checked behaviour.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // word addresses of the write port
   localparam logic ADDR_CFG = 1'b0;
   localparam logic ADDR_CMD = 1'b1;

   // configuration word field positions (select field follows the mode bit)
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_MODE_BIT = 1;
   localparam int CFG_SEL_LSB  = 2;

   // command word field positions
   localparam int CMD_RESTART_BIT = 0;
   localparam int CMD_CLEAR_BIT   = 1;

   typedef enum logic {
      ESC_TWO_STAGE = 1'b0,
      ESC_DIRECT    = 1'b1
   } esc_mode_e;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              cfg_en,
   output esc_mode_e         cfg_mode,
   output logic [SEL_W-1:0]  cfg_sel,
   output logic              locked,
   output logic              restart_cmd,
   output logic              clear_cmd
);

   localparam int LockBit = CFG_SEL_LSB + SEL_W;

   logic cfg_wr;
   logic cmd_wr;

   assign cfg_wr = wr_en && (wr_addr == ADDR_CFG);
   assign cmd_wr = wr_en && (wr_addr == ADDR_CMD);

   assign restart_cmd = cmd_wr && wr_data[CMD_RESTART_BIT];
   assign clear_cmd   = cmd_wr && wr_data[CMD_CLEAR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_en   <= 1'b0;
         cfg_mode <= ESC_TWO_STAGE;
         cfg_sel  <= '0;
      end else if (cfg_wr && !locked) begin
         cfg_en   <= wr_data[CFG_EN_BIT];
         cfg_mode <= esc_mode_e'(wr_data[CFG_MODE_BIT]);
         cfg_sel  <= wr_data[CFG_SEL_LSB +: SEL_W];
      end
   end

   // lock is sticky: only the reset clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (cfg_wr && wr_data[LockBit]) begin
         locked <= 1'b1;
      end
   end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int MIN_EXP = 16,
   parameter int SEL_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] sel,
   input  logic             restart,
   output logic             expire
);

   localparam int NumSel = 1 << SEL_W;
   localparam int CntW   = MIN_EXP + NumSel - 1;

   logic [CntW-1:0] count_q;
   logic [CntW-1:0] limit_tbl [NumSel];
   logic [CntW-1:0] limit;

   // one terminal value per selectable period
   for (genvar g = 0; g < NumSel; g++) begin : g_limit
      localparam longint unsigned Term = (64'd1 << (MIN_EXP + g)) - 64'd1;
      assign limit_tbl[g] = CntW'(Term);
   end

   assign limit  = limit_tbl[sel];
   assign expire = enable && !restart && (count_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (!enable || restart || expire) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
   import wdog_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  esc_mode_e mode,
   input  logic      clear_cmd,
   output logic      flag,
   output logic      rst_req
);

   logic flag_kept;
   logic flag_d;
   logic rst_d;

   // a clear in the same cycle counts as serviced
   assign flag_kept = flag && !clear_cmd;

   always_comb begin
      flag_d = flag_kept;
      rst_d  = 1'b0;
      if (expire) begin
         if (mode == ESC_DIRECT) begin
            rst_d = 1'b1;
         end else if (flag_kept) begin
            rst_d = 1'b1;
         end else begin
            flag_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         flag    <= flag_d;
         rst_req <= rst_d;
      end
   end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
   import wdog_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SEL_W   = 4,
   parameter int MIN_EXP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq_o,
   output logic              flag_o,
   output logic              rst_req_o,
   output logic              locked_o
);

   localparam int NumSel  = 1 << SEL_W;
   localparam int MaxExp  = MIN_EXP + NumSel - 1;

   if (MIN_EXP < 1) begin : g_bad_min
      $error("wdog_two_stage: MIN_EXP must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("wdog_two_stage: SEL_W must lie in 1..4");
   end
   if (MaxExp > 62) begin : g_bad_span
      $error("wdog_two_stage: longest period exceeds 2^62");
   end
   if (CFG_SEL_LSB + SEL_W + 1 > DATA_W) begin : g_bad_data
      $error("wdog_two_stage: DATA_W too narrow for the configuration word");
   end

   logic             cfg_en;
   esc_mode_e        cfg_mode;
   logic [SEL_W-1:0] cfg_sel;
   logic             restart_cmd;
   logic             clear_cmd;
   logic             expire;
   logic             flag;

   wdog_regs #(
      .DATA_W (DATA_W),
      .SEL_W  (SEL_W)
   ) i_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .cfg_en      (cfg_en),
      .cfg_mode    (cfg_mode),
      .cfg_sel     (cfg_sel),
      .locked      (locked_o),
      .restart_cmd (restart_cmd),
      .clear_cmd   (clear_cmd)
   );

   wdog_counter #(
      .MIN_EXP (MIN_EXP),
      .SEL_W   (SEL_W)
   ) i_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (cfg_en),
      .sel     (cfg_sel),
      .restart (restart_cmd),
      .expire  (expire)
   );

   wdog_escalate i_escalate (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .mode      (cfg_mode),
      .clear_cmd (clear_cmd),
      .flag      (flag),
      .rst_req   (rst_req_o)
   );

   assign flag_o = flag;
   assign irq_o  = flag;

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
   import wdog_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              flag_o,
   input logic              rst_req_o,
   input logic              locked_o,
   input logic              cfg_en,
   input esc_mode_e         cfg_mode
);

   logic cmd_clear;
   logic cmd_restart;

   assign cmd_clear   = wr_en && (wr_addr == ADDR_CMD) && wr_data[CMD_CLEAR_BIT];
   assign cmd_restart = wr_en && (wr_addr == ADDR_CMD) && wr_data[CMD_RESTART_BIT];

   // R5 and R8: the reset request never lasts two cycles
   assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);

   // R8: a reset request needs a set flag or direct mode in the cycle before
   assert_rst_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> ($past(flag_o) || $past(cfg_mode) == ESC_DIRECT));

   assert_flag_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(cfg_mode) == ESC_TWO_STAGE);

   assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> $past(cmd_clear));

   assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_restart |=> !rst_req_o);

   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> locked_o);

   assert_lock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      locked_o |=> ($stable(cfg_en) && $stable(cfg_mode)));

endmodule

bind wdog_two_stage wdog_two_stage_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .flag_o    (flag_o),
   .rst_req_o (rst_req_o),
   .locked_o  (locked_o),
   .cfg_en    (cfg_en),
   .cfg_mode  (cfg_mode)
);

// File: tb/test_wdog_two_stage.sv
`timescale 1ns/1ps
module test_wdog_two_stage;

   localparam int DATA_W  = 8;
   localparam int SEL_W   = 4;
   localparam int MIN_EXP = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic              wr_addr = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              irq_o;
   logic              flag_o;
   logic              rst_req_o;
   logic              locked_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   wdog_two_stage #(
      .DATA_W  (DATA_W),
      .SEL_W   (SEL_W),
      .MIN_EXP (MIN_EXP)
   ) i_wdog_two_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .irq_o     (irq_o),
      .flag_o    (flag_o),
      .rst_req_o (rst_req_o),
      .locked_o  (locked_o)
   );

   function automatic logic [7:0] cfg(input logic en, input logic mode,
                                      input logic [3:0] sel, input logic lock);
      return {1'b0, lock, sel, mode, en};
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // called at a falling edge, returns at the falling edge after the write
   task automatic wr(input logic a, input logic [7:0] d);
      wr_en = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = '0;
   endtask

   task automatic watch(input int max_n, output int first_flag,
                        output int first_rst, output int rst_cnt);
      first_flag = 0;
      first_rst = 0;
      rst_cnt = 0;
      for (int n = 1; n <= max_n; n++) begin
         @(posedge clk);
         @(negedge clk);
         if (flag_o && first_flag == 0) first_flag = n;
         if (rst_req_o) begin
            rst_cnt++;
            if (first_rst == 0) first_rst = n;
         end
      end
   endtask

   task automatic t_reset();
      do_reset();
      check(!irq_o && !flag_o && !rst_req_o && !locked_o, "R1 reset outputs",
            {irq_o, flag_o, rst_req_o, locked_o}, 0);
   endtask

   task automatic t_two_stage();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd1, 1'b0));
      watch(20, ff, fr, rc);
      check(ff == 8, "R4 first flag cycle", ff, 8);
      check(irq_o == 1'b1, "R4 irq raised", irq_o, 1);
      check(fr == 16, "R5 reset pulse cycle", fr, 16);
      check(rc == 1, "R5 single-cycle pulse", rc, 1);
      check(flag_o == 1'b1, "R5 flag kept", flag_o, 1);
   endtask

   task automatic t_clear();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd0, 1'b0));
      watch(4, ff, fr, rc);
      check(ff == 4, "R2 first expiry after enable", ff, 4);
      wr(1'b1, 8'h02);
      check(!flag_o && !irq_o, "R6 clear lowers flag and irq", {flag_o, irq_o}, 0);
      watch(3, ff, fr, rc);
      check(ff == 3 && rc == 0, "R6 next expiry is first stage", rc, 0);
   endtask

   task automatic t_period();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd3, 1'b0));
      watch(32, ff, fr, rc);
      check(ff == 32, "R3 period select 3", ff, 32);
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd7, 1'b0));
      watch(512, ff, fr, rc);
      check(ff == 512, "R3 period select 7", ff, 512);
   endtask

   task automatic t_restart();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd2, 1'b0));
      repeat (10) begin
         @(posedge clk);
         @(negedge clk);
      end
      wr(1'b1, 8'h01);
      watch(16, ff, fr, rc);
      check(ff == 16, "R7 restart delays expiry", ff, 16);
      wr(1'b1, 8'h01);
      check(flag_o == 1'b1, "R7 restart keeps flag", flag_o, 1);
      watch(16, ff, fr, rc);
      check(fr == 16 && rc == 1, "R7 reset one period after restart", fr, 16);
   endtask

   task automatic t_disable();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b0, 1'b0, 4'd0, 1'b0));
      watch(50, ff, fr, rc);
      check(ff == 0 && rc == 0, "R2 disabled never expires", ff + rc, 0);
      wr(1'b0, cfg(1'b1, 1'b0, 4'd0, 1'b0));
      @(posedge clk);
      @(negedge clk);
      wr(1'b0, cfg(1'b0, 1'b0, 4'd0, 1'b0));
      check(flag_o == 1'b0, "R2 no flag before period", flag_o, 0);
      wr(1'b0, cfg(1'b1, 1'b0, 4'd0, 1'b0));
      watch(4, ff, fr, rc);
      check(ff == 4, "R2 count restarts at zero", ff, 4);
   endtask

   task automatic t_direct();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b1, 4'd0, 1'b0));
      watch(10, ff, fr, rc);
      check(fr == 4, "R8 direct reset cycle", fr, 4);
      check(rc == 2, "R8 reset each expiry", rc, 2);
      check(ff == 0 && !irq_o, "R8 flag never set", ff, 0);
   endtask

   task automatic t_lock();
      int ff, fr, rc;
      do_reset();
      wr(1'b0, cfg(1'b1, 1'b0, 4'd0, 1'b1));
      check(locked_o == 1'b1, "R9 lock reported", locked_o, 1);
      wr(1'b0, cfg(1'b0, 1'b1, 4'd3, 1'b0));
      watch(3, ff, fr, rc);
      check(ff == 3 && rc == 0, "R9 locked fields ignored", ff, 3);
      check(locked_o == 1'b1, "R9 lock sticky", locked_o, 1);
      do_reset();
      check(locked_o == 1'b0, "R9 reset clears lock", locked_o, 0);
   endtask

   initial begin
      t_reset();
      t_two_stage();
      t_clear();
      t_period();
      t_restart();
      t_disable();
      t_direct();
      t_lock();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule